// File: doc/BRIEF.md
# Serial Port Control Register with Output Flag Buffering

This block holds the 24-bit control word of a synchronous serial port that has up to three transmitters. It also keeps the transmit-side state that sits next to that word. A processor bus writes the control word, writes the three transmit data registers, and reads the control word back. The fields of the word drive the port's enables, its frame and clock format options, the direction of the three serial control pins and of the serial clock, and the interrupt gating.

A frame-sync transfer strobe moves pending transmit data into the shift registers of the transmitters that are enabled. The same strobe moves the two output flag bits from the control word onto the flag pins. Software waits for transmitter 0's empty status, writes the flag bits, then writes the next data word, so each flag value leaves together with its data word. A transfer that finds an enabled transmitter with no new data sets a sticky underrun status. That status can raise an exception interrupt.

Top module: `ssp_ctrl`

## Requirements
- R1: After hardware reset (rst_ni low), ctrl_rdata_o is 0, tx_empty_o is all ones, oflag_o is 0, tx_underrun_o is 0, shift_data_o is 0 and every interrupt output is 0.
- R2: A cycle with soft_rst_i high returns the whole block to the state of R1 on the next clock edge. This includes clearing a sticky underrun.
- R3: A control write (ctrl_we_i) stores ctrl_wdata_i, and ctrl_rdata_o shows exactly that value from the next cycle on. The field positions are: bits 1:0 flag bits, bits 4:2 pin directions (bit 2 for pin 0), bit 5 serial clock direction, bit 6 LSB-first, bits 8:7 frame-sync length, bit 9 early frame sync, bit 10 frame-sync polarity, bit 11 clock polarity, bit 12 synchronous mode, bit 13 network mode, bit 14 transmitter 2 enable, bit 15 transmitter 1 enable, bit 16 transmitter 0 enable, bit 17 receive enable, bit 18 transmit interrupt enable, bit 19 receive interrupt enable, bit 20 transmit last-slot interrupt enable, bit 21 receive last-slot interrupt enable, bit 22 transmit exception interrupt enable, bit 23 receive exception interrupt enable.
- R4: The control outputs follow the stored fields combinationally. tx_en_o[i] is the enable of transmitter i. pin_oe_o is {clock direction, pin directions 2..0}, where 1 means the pin is driven. The remaining format outputs each carry their field.
- R5: Writing transmit data register i (tx_we_i[i]) clears tx_empty_o[i] on the next cycle and leaves the other transmitters' empty bits unchanged.
- R6: On fs_xfer_i, each enabled transmitter i loads its data register into shift_data_o[i*DATA_W +: DATA_W] and sets tx_empty_o[i]. A disabled transmitter keeps both its shift data and its empty bit.
- R7: Writing the flag bits of the control word does not change oflag_o until the next fs_xfer_i.
- R8: On fs_xfer_i, oflag_o takes the stored flag bits whether or not any transmitter or the receiver is enabled.
- R9: An fs_xfer_i that finds an enabled transmitter with its empty bit set raises tx_underrun_o. The flag stays set until a reset. A transfer in which every enabled transmitter holds new data does not raise it.
- R10: tx_irq_o = bit 18 AND tx_empty_o[0]; tx_exc_irq_o = bit 22 AND tx_underrun_o; rx_irq_o = bit 19 AND rx_full_i; rx_exc_irq_o = bit 23 AND rx_ovr_i; tx_last_irq_o = bit 20 AND slot_end_i; rx_last_irq_o = bit 21 AND slot_end_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| soft_rst_i | input | 1 | Synchronous software reset command |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 24 | Control word write data |
| ctrl_rdata_o | output | 24 | Control word readback |
| tx_we_i | input | 3 | Per-transmitter data write strobes |
| tx_wdata_i | input | DATA_W | Transmit data write value |
| fs_xfer_i | input | 1 | Frame-sync transfer strobe |
| rx_full_i | input | 1 | Receive data full status |
| rx_ovr_i | input | 1 | Receive overrun status |
| slot_end_i | input | 1 | Last time slot of frame reached |
| shift_data_o | output | 3*DATA_W | Shift register contents, transmitter i at i*DATA_W |
| tx_empty_o | output | 3 | Per-transmitter data empty status |
| tx_underrun_o | output | 1 | Sticky transmit underrun |
| oflag_o | output | 2 | Serial output flag pins |
| tx_en_o | output | 3 | Transmitter enables |
| rx_en_o | output | 1 | Receiver enable |
| pin_oe_o | output | 4 | Output enables: clock, pins 2..0 |
| lsb_first_o | output | 1 | Shift direction |
| fs_len_o | output | 2 | Frame-sync length |
| fs_early_o | output | 1 | Early frame sync |
| fs_pol_o | output | 1 | Frame-sync polarity |
| clk_pol_o | output | 1 | Clock polarity |
| sync_mode_o | output | 1 | Synchronous mode |
| net_mode_o | output | 1 | Network mode |
| tx_irq_o | output | 1 | Transmit interrupt |
| rx_irq_o | output | 1 | Receive interrupt |
| tx_last_irq_o | output | 1 | Transmit last-slot interrupt |
| rx_last_irq_o | output | 1 | Receive last-slot interrupt |
| tx_exc_irq_o | output | 1 | Transmit exception interrupt |
| rx_exc_irq_o | output | 1 | Receive exception interrupt |

## Verification
The assertions check these rules on every cycle:
- a soft reset clears the control word, and a write is read back unchanged;
- data writes clear the empty bit of their transmitter;
- transfers set the empty bit and load the shift register only when that transmitter is enabled, and leave a disabled slot untouched;
- the flag pins hold between transfers and take the stored bits at a transfer;
- the underrun flag never drops without a reset.

Only the bench scenarios show the following:
- the exact field positions;
- that flags move while every enable is off;
- that a fully fed transfer raises no underrun;
- that each interrupt is gated by its own enable bit.

// File: rtl/ssp_ctrl_pkg.sv
package ssp_ctrl_pkg;
  localparam int CTRL_W = 24;
  localparam int NTX    = 3;
  localparam int NFLAG  = 2;
  localparam int NPIN   = 3;

  typedef struct packed {
    logic             rx_exc_ie;   // 23
    logic             tx_exc_ie;   // 22
    logic             rx_last_ie;  // 21
    logic             tx_last_ie;  // 20
    logic             rx_ie;       // 19
    logic             tx_ie;       // 18
    logic             rx_en;       // 17
    logic             tx_en0;      // 16
    logic             tx_en1;      // 15
    logic             tx_en2;      // 14
    logic             net_mode;    // 13
    logic             sync_mode;   // 12
    logic             clk_pol;     // 11
    logic             fs_pol;      // 10
    logic             fs_early;    // 9
    logic [1:0]       fs_len;      // 8:7
    logic             lsb_first;   // 6
    logic             sclk_dir;    // 5
    logic [NPIN-1:0]  pin_dir;     // 4:2
    logic [NFLAG-1:0] oflag;       // 1:0
  } ctrl_t;
endpackage

// File: rtl/ssp_ctrl_reg.sv
module ssp_ctrl_reg
  import ssp_ctrl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output ctrl_t             ctrl_o
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         ctrl_q <= '0;
    else if (soft_rst_i) ctrl_q <= '0;
    else if (we_i)       ctrl_q <= ctrl_t'(wdata_i);
  end

  assign ctrl_o = ctrl_q;

  // R2
  soft_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (ctrl_o == '0));
  // R3
  write_back_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !soft_rst_i) |=> (CTRL_W'(ctrl_o) == $past(wdata_i)));
endmodule

// File: rtl/ssp_tx_slot.sv
module ssp_tx_slot #(
  parameter int DATA_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              en_i,
  input  logic              xfer_i,
  output logic              empty_o,
  output logic [DATA_W-1:0] shift_o,
  output logic              starve_o
);
  logic [DATA_W-1:0] data_q, shift_q;
  logic              empty_q;
  logic              load;

  assign load = xfer_i && en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      shift_q <= '0;
      empty_q <= 1'b1;
    end else if (soft_rst_i) begin
      data_q  <= '0;
      shift_q <= '0;
      empty_q <= 1'b1;
    end else begin
      if (load) shift_q <= data_q;
      // a write in the transfer cycle holds new data for the next frame
      if (wr_i) begin
        data_q  <= wdata_i;
        empty_q <= 1'b0;
      end else if (load) begin
        empty_q <= 1'b1;
      end
    end
  end

  assign empty_o  = empty_q;
  assign shift_o  = shift_q;
  assign starve_o = load && empty_q;

  // R5
  wr_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !soft_rst_i) |=> !empty_o);
  // R6
  xfer_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_i && en_i && !wr_i && !soft_rst_i) |=> empty_o);
  // R6
  xfer_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_i && en_i && !soft_rst_i) |=> (shift_o == $past(data_q)));
  // R6
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(xfer_i && en_i) && !soft_rst_i) |=> $stable(shift_o));
endmodule

// File: rtl/ssp_flag_buf.sv
module ssp_flag_buf #(
  parameter int NF = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          soft_rst_i,
  input  logic          xfer_i,
  input  logic [NF-1:0] pend_i,
  output logic [NF-1:0] flag_o
);
  logic [NF-1:0] flag_q;

  // enables deliberately not consulted: flags follow frame timing only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_q <= '0;
    else if (soft_rst_i) flag_q <= '0;
    else if (xfer_i)     flag_q <= pend_i;
  end

  assign flag_o = flag_q;

  // R7
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!xfer_i && !soft_rst_i) |=> $stable(flag_o));
  // R8
  flag_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_i && !soft_rst_i) |=> (flag_o == $past(pend_i)));
endmodule

// File: rtl/ssp_irq.sv
module ssp_irq #(
  parameter int NT = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          soft_rst_i,
  input  logic [NT-1:0] starve_i,
  input  logic          empty0_i,
  input  logic          tx_ie_i,
  input  logic          rx_ie_i,
  input  logic          tx_last_ie_i,
  input  logic          rx_last_ie_i,
  input  logic          tx_exc_ie_i,
  input  logic          rx_exc_ie_i,
  input  logic          rx_full_i,
  input  logic          rx_ovr_i,
  input  logic          slot_end_i,
  output logic          underrun_o,
  output logic          tx_irq_o,
  output logic          rx_irq_o,
  output logic          tx_last_irq_o,
  output logic          rx_last_irq_o,
  output logic          tx_exc_irq_o,
  output logic          rx_exc_irq_o
);
  logic underrun_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         underrun_q <= 1'b0;
    else if (soft_rst_i) underrun_q <= 1'b0;
    else if (|starve_i)  underrun_q <= 1'b1;
  end

  assign underrun_o    = underrun_q;
  assign tx_irq_o      = tx_ie_i      && empty0_i;
  assign rx_irq_o      = rx_ie_i      && rx_full_i;
  assign tx_last_irq_o = tx_last_ie_i && slot_end_i;
  assign rx_last_irq_o = rx_last_ie_i && slot_end_i;
  assign tx_exc_irq_o  = tx_exc_ie_i  && underrun_q;
  assign rx_exc_irq_o  = rx_exc_ie_i  && rx_ovr_i;

  // R9
  underrun_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underrun_o && !soft_rst_i) |=> underrun_o);
  // R9
  underrun_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|starve_i) && !soft_rst_i) |=> underrun_o);
endmodule

// File: rtl/ssp_ctrl.sv
module ssp_ctrl
  import ssp_ctrl_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  soft_rst_i,
  input  logic                  ctrl_we_i,
  input  logic [23:0]           ctrl_wdata_i,
  output logic [23:0]           ctrl_rdata_o,
  input  logic [2:0]            tx_we_i,
  input  logic [DATA_W-1:0]     tx_wdata_i,
  input  logic                  fs_xfer_i,
  input  logic                  rx_full_i,
  input  logic                  rx_ovr_i,
  input  logic                  slot_end_i,
  output logic [3*DATA_W-1:0]   shift_data_o,
  output logic [2:0]            tx_empty_o,
  output logic                  tx_underrun_o,
  output logic [1:0]            oflag_o,
  output logic [2:0]            tx_en_o,
  output logic                  rx_en_o,
  output logic [3:0]            pin_oe_o,
  output logic                  lsb_first_o,
  output logic [1:0]            fs_len_o,
  output logic                  fs_early_o,
  output logic                  fs_pol_o,
  output logic                  clk_pol_o,
  output logic                  sync_mode_o,
  output logic                  net_mode_o,
  output logic                  tx_irq_o,
  output logic                  rx_irq_o,
  output logic                  tx_last_irq_o,
  output logic                  rx_last_irq_o,
  output logic                  tx_exc_irq_o,
  output logic                  rx_exc_irq_o
);
  ctrl_t          ctrl;
  logic [NTX-1:0] tx_en;
  logic [NTX-1:0] starve;

  ssp_ctrl_reg i_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst_i),
    .we_i       (ctrl_we_i),
    .wdata_i    (ctrl_wdata_i),
    .ctrl_o     (ctrl)
  );

  assign tx_en = {ctrl.tx_en2, ctrl.tx_en1, ctrl.tx_en0};

  for (genvar g = 0; g < NTX; g++) begin : g_slot
    ssp_tx_slot #(.DATA_W(DATA_W)) i_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .soft_rst_i (soft_rst_i),
      .wr_i       (tx_we_i[g]),
      .wdata_i    (tx_wdata_i),
      .en_i       (tx_en[g]),
      .xfer_i     (fs_xfer_i),
      .empty_o    (tx_empty_o[g]),
      .shift_o    (shift_data_o[g*DATA_W +: DATA_W]),
      .starve_o   (starve[g])
    );
  end

  ssp_flag_buf #(.NF(NFLAG)) i_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst_i),
    .xfer_i     (fs_xfer_i),
    .pend_i     (ctrl.oflag),
    .flag_o     (oflag_o)
  );

  ssp_irq #(.NT(NTX)) i_irq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .soft_rst_i    (soft_rst_i),
    .starve_i      (starve),
    .empty0_i      (tx_empty_o[0]),
    .tx_ie_i       (ctrl.tx_ie),
    .rx_ie_i       (ctrl.rx_ie),
    .tx_last_ie_i  (ctrl.tx_last_ie),
    .rx_last_ie_i  (ctrl.rx_last_ie),
    .tx_exc_ie_i   (ctrl.tx_exc_ie),
    .rx_exc_ie_i   (ctrl.rx_exc_ie),
    .rx_full_i     (rx_full_i),
    .rx_ovr_i      (rx_ovr_i),
    .slot_end_i    (slot_end_i),
    .underrun_o    (tx_underrun_o),
    .tx_irq_o      (tx_irq_o),
    .rx_irq_o      (rx_irq_o),
    .tx_last_irq_o (tx_last_irq_o),
    .rx_last_irq_o (rx_last_irq_o),
    .tx_exc_irq_o  (tx_exc_irq_o),
    .rx_exc_irq_o  (rx_exc_irq_o)
  );

  assign ctrl_rdata_o = CTRL_W'(ctrl);
  assign tx_en_o      = tx_en;
  assign rx_en_o      = ctrl.rx_en;
  assign pin_oe_o     = {ctrl.sclk_dir, ctrl.pin_dir};
  assign lsb_first_o  = ctrl.lsb_first;
  assign fs_len_o     = ctrl.fs_len;
  assign fs_early_o   = ctrl.fs_early;
  assign fs_pol_o     = ctrl.fs_pol;
  assign clk_pol_o    = ctrl.clk_pol;
  assign sync_mode_o  = ctrl.sync_mode;
  assign net_mode_o   = ctrl.net_mode;

  // R1
  rst_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (tx_empty_o == '1 && oflag_o == '0 && !tx_underrun_o));
endmodule

// File: tb/test_ssp_ctrl.sv
`timescale 1ns/1ps
module test_ssp_ctrl;
  localparam int W = 24;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          soft_rst_i = 1'b0;
  logic          ctrl_we_i = 1'b0;
  logic [23:0]   ctrl_wdata_i = '0;
  logic [23:0]   ctrl_rdata_o;
  logic [2:0]    tx_we_i = '0;
  logic [W-1:0]  tx_wdata_i = '0;
  logic          fs_xfer_i = 1'b0;
  logic          rx_full_i = 1'b0;
  logic          rx_ovr_i = 1'b0;
  logic          slot_end_i = 1'b0;
  logic [3*W-1:0] shift_data_o;
  logic [2:0]    tx_empty_o;
  logic          tx_underrun_o;
  logic [1:0]    oflag_o;
  logic [2:0]    tx_en_o;
  logic          rx_en_o;
  logic [3:0]    pin_oe_o;
  logic          lsb_first_o;
  logic [1:0]    fs_len_o;
  logic          fs_early_o, fs_pol_o, clk_pol_o, sync_mode_o, net_mode_o;
  logic          tx_irq_o, rx_irq_o, tx_last_irq_o, rx_last_irq_o;
  logic          tx_exc_irq_o, rx_exc_irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  ssp_ctrl #(.DATA_W(W)) i_ssp_ctrl (.*);

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic wr_ctrl(input logic [23:0] v);
    ctrl_we_i = 1'b1; ctrl_wdata_i = v;
    tick();
    ctrl_we_i = 1'b0;
  endtask

  task automatic wr_tx(input int i, input logic [W-1:0] v);
    tx_we_i = 3'b001 << i; tx_wdata_i = v;
    tick();
    tx_we_i = '0;
  endtask

  task automatic xfer();
    fs_xfer_i = 1'b1;
    tick();
    fs_xfer_i = 1'b0;
  endtask

  task automatic t_reset();
    chk(ctrl_rdata_o, 0, "R1 ctrl");
    chk(tx_empty_o, 3'b111, "R1 empty");
    chk(oflag_o, 0, "R1 flags");
    chk(tx_underrun_o, 0, "R1 underrun");
    chk(shift_data_o, 0, "R1 shift");
    chk({tx_irq_o, rx_irq_o, tx_last_irq_o, rx_last_irq_o, tx_exc_irq_o, rx_exc_irq_o}, 0, "R1 irqs");
  endtask

  task automatic t_fields();
    wr_ctrl(24'h5A3C96);
    chk(ctrl_rdata_o, 24'h5A3C96, "R3 readback");
    // bits 16/15/14 = 0,0,0 of 0x5A3C96 -> 0x5A=0101_1010: bit22,20,19,17 set
    chk(tx_en_o, 3'b000, "R4 tx_en");
    chk(rx_en_o, 1'b1, "R4 rx_en");
    // 0x3C96 low: bits13..0 = 11_1100_1001_0110
    chk({net_mode_o, sync_mode_o, clk_pol_o, fs_pol_o, fs_early_o}, 5'b11110, "R4 mode bits");
    chk({fs_len_o, lsb_first_o}, 3'b010, "R4 fs_len lsb");
    chk(pin_oe_o, 4'b0101, "R4 pin_oe");
    chk(oflag_o, 0, "R7 flags not moved by write");
    wr_ctrl(24'h01C023);
    chk(ctrl_rdata_o, 24'h01C023, "R3 readback2");
    chk(tx_en_o, 3'b111, "R4 tx_en all");
    chk(pin_oe_o, 4'b1000, "R4 clock dir");
    wr_ctrl(24'h040000);
    chk(tx_irq_o, 1'b1, "R10 tx irq with empty0");
    wr_ctrl(24'h000000);
    chk(tx_irq_o, 1'b0, "R10 tx irq gated");
  endtask

  task automatic t_xfer();
    wr_ctrl(24'h018000);               // tx0, tx1 enabled
    wr_tx(0, 24'h111111);
    chk(tx_empty_o, 3'b110, "R5 empty0 cleared only");
    wr_tx(1, 24'h222222);
    chk(tx_empty_o, 3'b100, "R5 empty1 cleared");
    xfer();
    chk(shift_data_o[0 +: W], 24'h111111, "R6 shift0");
    chk(shift_data_o[W +: W], 24'h222222, "R6 shift1");
    chk(shift_data_o[2*W +: W], 0, "R6 shift2 disabled");
    chk(tx_empty_o, 3'b111, "R6 empties set");
    chk(tx_underrun_o, 1'b0, "R9 no underrun when fed");
  endtask

  task automatic t_flags();
    wr_ctrl(24'h000002);               // all disabled, flag1 pending
    chk(oflag_o, 2'b00, "R7 flags held");
    xfer();
    chk(oflag_o, 2'b10, "R8 flags moved with enables off");
    wr_ctrl(24'h000001);
    tick();
    chk(oflag_o, 2'b10, "R7 flags held after rewrite");
    xfer();
    chk(oflag_o, 2'b01, "R8 second move");
  endtask

  task automatic t_underrun();
    wr_ctrl(24'h404000);               // tx2 enabled, exc irq enabled
    xfer();
    chk(tx_underrun_o, 1'b1, "R9 underrun raised");
    chk(tx_exc_irq_o, 1'b1, "R10 exc irq");
    wr_ctrl(24'h004000);
    chk(tx_exc_irq_o, 1'b0, "R10 exc irq gated");
    tick();
    chk(tx_underrun_o, 1'b1, "R9 underrun sticky");
    soft_rst_i = 1'b1;
    tick();
    soft_rst_i = 1'b0;
    chk(ctrl_rdata_o, 0, "R2 soft ctrl");
    chk(tx_underrun_o, 0, "R2 soft underrun");
    chk(tx_empty_o, 3'b111, "R2 soft empty");
    chk(shift_data_o, 0, "R2 soft shift");
    wr_tx(2, 24'h333333);
    xfer();                            // tx2 disabled
    chk(tx_empty_o, 3'b011, "R6 disabled keeps empty");
    chk(shift_data_o[2*W +: W], 0, "R6 disabled keeps shift");
  endtask

  task automatic t_rx_irq();
    wr_ctrl(24'hB80000);               // bits 23,21,20,19
    rx_full_i = 1'b1; #1;
    chk(rx_irq_o, 1'b1, "R10 rx irq");
    rx_full_i = 1'b0; rx_ovr_i = 1'b1; #1;
    chk({rx_irq_o, rx_exc_irq_o}, 2'b01, "R10 rx exc irq");
    rx_ovr_i = 1'b0; slot_end_i = 1'b1; #1;
    chk({tx_last_irq_o, rx_last_irq_o}, 2'b11, "R10 last-slot irqs");
    rx_full_i = 1'b1; rx_ovr_i = 1'b1;
    wr_ctrl(24'h000000);
    chk({rx_irq_o, rx_exc_irq_o, tx_last_irq_o, rx_last_irq_o}, 0, "R10 all gated");
    rx_full_i = 1'b0; rx_ovr_i = 1'b0; slot_end_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    t_reset();
    rst_ni = 1'b1;
    tick();
    t_reset();
    t_fields();
    t_xfer();
    t_flags();
    t_underrun();
    t_rx_irq();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule